// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block sits between a 12-bit narrow port (A) and a 24-bit wide port (B) and moves data across synchronously in either direction. The wide port is handled as two 12-bit halves: the low half (bits 11:0, called the lo half) and the high half (bits 23:12, called the hi half). Going from narrow to wide, the lo half is fed by a two-register pipeline and the hi half by a single register. Two narrow words presented on consecutive clocks therefore come out side by side as one wide word.

Going from wide to narrow, each half of B is stored in its own register. A registered select decides which stored half drives A. Every storage path has its own active-low clock enable. The two port enables and the select are sampled on the clock, so direction changes take effect only at clock edges. Each tri-state port is modelled as a data bus plus a drive flag. A port whose flag is low carries all-zero data.

Top module: `exch_narrow_wide`

## Requirements
- R1: While rst_ni is low, a_oe_o and b_oe_o are 0 and a_o and b_o are all zero, with no clock edge needed.
- R2: a_oe_o and b_oe_o each equal the inverse of oea_ni / oeb_ni as sampled at the last rising edge. A change of those inputs has no effect before the next edge.
- R3: When a port's drive flag is 0, that port's data output is all zero.
- R4: The hi half of b_o (bits 23:12) takes a_i at a rising edge where clken_hi_ni is 0. At edges where clken_hi_ni is 1 it holds its value, and this includes any period during which B is not driven.
- R5: At a rising edge where clken_lo_ni is 0, both lo-path stages advance together. Stage one takes a_i and stage two, which is bits 11:0 of b_o, takes the old stage one. Once clken_lo_ni has been 0 for two edges in a row, b_o[11:0] equals the a_i of the earlier of those two edges.
- R6: Take word w0 with only clken_lo_ni low, then word w1 on the next edge with both clken_lo_ni and clken_hi_ni low. After that edge, b_o equals {w1, w0}.
- R7: The wide-to-narrow registers capture b_i[11:0] (clken_blo_ni low) and b_i[23:12] (clken_bhi_ni low) independently at a rising edge. Otherwise each holds its value.
- R8: sel_ni is registered. A 0 sampled at an edge makes a_o show the lo stored half from that edge on. A 1 makes it show the hi stored half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 12 | Narrow port input data |
| b_i | input | 24 | Wide port input data |
| clken_lo_ni | input | 1 | Enable for the narrow-to-lo pipeline, active low |
| clken_hi_ni | input | 1 | Enable for the narrow-to-hi register, active low |
| clken_blo_ni | input | 1 | Enable for the stored lo half toward A, active low |
| clken_bhi_ni | input | 1 | Enable for the stored hi half toward A, active low |
| sel_ni | input | 1 | Half select for A, 0 = lo, 1 = hi (registered) |
| oea_ni | input | 1 | Drive request for A, active low (registered) |
| oeb_ni | input | 1 | Drive request for B, active low (registered) |
| a_o | output | 12 | Narrow port output data |
| a_oe_o | output | 1 | Narrow port drive flag |
| b_o | output | 24 | Wide port output data |
| b_oe_o | output | 1 | Wide port drive flag |

## Verification
The bench runs the pairing sequence and then walks the lo pipeline word by word. A design that gave the lo path only one stage, or advanced the two stages on different enables, would show the newer word in the lo half instead of the older one. The bench toggles the enables and the select between edges and checks the outputs before the edge. A design that passed these controls straight through would change the port ahead of the clock. It also changes b_i and the hi-half input while their enables are high, and it disables and then re-enables B. A design that captured when it should hold, or lost state while a port was idle, would show the wrong half on the next read.

// File: rtl/exch_pkg.sv
package exch_pkg;
  localparam int unsigned DEF_HALF_W    = 12;
  localparam int unsigned DEF_LO_STAGES = 2;

  typedef enum logic {
    PICK_LO = 1'b0,
    PICK_HI = 1'b1
  } pick_e;
endpackage

// File: rtl/exch_en_reg.sv
module exch_en_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end
endmodule

// File: rtl/exch_narrow_to_wide.sv
module exch_narrow_to_wide #(
  parameter int unsigned W         = exch_pkg::DEF_HALF_W,
  parameter int unsigned LO_STAGES = exch_pkg::DEF_LO_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_lo_ni,
  input  logic         en_hi_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic [W-1:0] chain [LO_STAGES+1];

  assign chain[0] = a_i;

  // all lo stages share one enable so the pipeline shifts as a unit
  for (genvar s = 0; s < LO_STAGES; s++) begin : g_lo
    exch_en_reg #(.W(W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_ni (en_lo_ni),
      .d_i   (chain[s]),
      .q_o   (chain[s+1])
    );
  end

  assign lo_o = chain[LO_STAGES];

  exch_en_reg #(.W(W)) u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_hi_ni),
    .d_i   (a_i),
    .q_o   (hi_o)
  );
endmodule

// File: rtl/exch_wide_to_narrow.sv
module exch_wide_to_narrow #(
  parameter int unsigned W = exch_pkg::DEF_HALF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_lo_ni,
  input  logic            en_hi_ni,
  input  logic [2*W-1:0]  b_i,
  input  exch_pkg::pick_e pick_i,
  output logic [W-1:0]    a_o
);
  logic [W-1:0] lo_q, hi_q;

  exch_en_reg #(.W(W)) u_lo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_lo_ni),
    .d_i   (b_i[W-1:0]),
    .q_o   (lo_q)
  );

  exch_en_reg #(.W(W)) u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_hi_ni),
    .d_i   (b_i[2*W-1:W]),
    .q_o   (hi_q)
  );

  assign a_o = (pick_i == exch_pkg::PICK_HI) ? hi_q : lo_q;
endmodule

// File: rtl/exch_port_ctrl.sv
module exch_port_ctrl #(
  parameter int unsigned W = exch_pkg::DEF_HALF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            oea_ni,
  input  logic            oeb_ni,
  input  logic            sel_ni,
  input  logic [W-1:0]    a_raw_i,
  input  logic [2*W-1:0]  b_raw_i,
  output exch_pkg::pick_e pick_o,
  output logic [W-1:0]    a_o,
  output logic            a_oe_o,
  output logic [2*W-1:0]  b_o,
  output logic            b_oe_o
);
  logic a_oe_q, b_oe_q;
  exch_pkg::pick_e pick_q;

  // direction controls are sampled so turnaround aligns to the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_oe_q <= 1'b0;
      b_oe_q <= 1'b0;
      pick_q <= exch_pkg::PICK_LO;
    end else begin
      a_oe_q <= ~oea_ni;
      b_oe_q <= ~oeb_ni;
      pick_q <= sel_ni ? exch_pkg::PICK_HI : exch_pkg::PICK_LO;
    end
  end

  assign pick_o = pick_q;
  assign a_oe_o = a_oe_q;
  assign b_oe_o = b_oe_q;
  assign a_o    = a_oe_q ? a_raw_i : '0;
  assign b_o    = b_oe_q ? b_raw_i : '0;
endmodule

// File: rtl/exch_narrow_wide.sv
module exch_narrow_wide #(
  parameter int unsigned HALF_W    = exch_pkg::DEF_HALF_W,
  parameter int unsigned LO_STAGES = exch_pkg::DEF_LO_STAGES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HALF_W-1:0]   a_i,
  input  logic [2*HALF_W-1:0] b_i,
  input  logic                clken_lo_ni,
  input  logic                clken_hi_ni,
  input  logic                clken_blo_ni,
  input  logic                clken_bhi_ni,
  input  logic                sel_ni,
  input  logic                oea_ni,
  input  logic                oeb_ni,
  output logic [HALF_W-1:0]   a_o,
  output logic                a_oe_o,
  output logic [2*HALF_W-1:0] b_o,
  output logic                b_oe_o
);
  localparam int unsigned WIDE_W = 2 * HALF_W;

  logic [HALF_W-1:0] nw_lo, nw_hi, a_raw;
  logic [WIDE_W-1:0] b_raw;
  exch_pkg::pick_e   pick;

  exch_narrow_to_wide #(.W(HALF_W), .LO_STAGES(LO_STAGES)) u_n2w (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_lo_ni(clken_lo_ni),
    .en_hi_ni(clken_hi_ni),
    .a_i     (a_i),
    .lo_o    (nw_lo),
    .hi_o    (nw_hi)
  );

  assign b_raw = {nw_hi, nw_lo};

  exch_wide_to_narrow #(.W(HALF_W)) u_w2n (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_lo_ni(clken_blo_ni),
    .en_hi_ni(clken_bhi_ni),
    .b_i     (b_i),
    .pick_i  (pick),
    .a_o     (a_raw)
  );

  exch_port_ctrl #(.W(HALF_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .oea_ni (oea_ni),
    .oeb_ni (oeb_ni),
    .sel_ni (sel_ni),
    .a_raw_i(a_raw),
    .b_raw_i(b_raw),
    .pick_o (pick),
    .a_o    (a_o),
    .a_oe_o (a_oe_o),
    .b_o    (b_o),
    .b_oe_o (b_oe_o)
  );
endmodule

// File: rtl/exch_narrow_wide_checks.sv
module exch_narrow_wide_checks #(
  parameter int unsigned HALF_W = exch_pkg::DEF_HALF_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [HALF_W-1:0]   a_i,
  input logic                clken_lo_ni,
  input logic                clken_hi_ni,
  input logic                oea_ni,
  input logic                oeb_ni,
  input logic [HALF_W-1:0]   a_o,
  input logic                a_oe_o,
  input logic [2*HALF_W-1:0] b_o,
  input logic                b_oe_o
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_a_oe_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1) |-> (a_oe_o == !$past(oea_ni)));

  assert_b_oe_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1) |-> (b_oe_o == !$past(oeb_ni)));

  assert_a_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_oe_o |-> (a_o == '0));

  assert_hi_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 2'd1) && !$past(clken_hi_ni) && b_oe_o)
      |-> (b_o[2*HALF_W-1:HALF_W] == $past(a_i)));

  assert_hi_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 2'd1) && $past(clken_hi_ni) && b_oe_o && $past(b_oe_o))
      |-> (b_o[2*HALF_W-1:HALF_W] == $past(b_o[2*HALF_W-1:HALF_W])));

  assert_lo_pipe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 2'd2) && !$past(clken_lo_ni) && !$past(clken_lo_ni, 2) && b_oe_o)
      |-> (b_o[HALF_W-1:0] == $past(a_i, 2)));
endmodule

bind exch_narrow_wide exch_narrow_wide_checks #(.HALF_W(HALF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_i        (a_i),
  .clken_lo_ni(clken_lo_ni),
  .clken_hi_ni(clken_hi_ni),
  .oea_ni     (oea_ni),
  .oeb_ni     (oeb_ni),
  .a_o        (a_o),
  .a_oe_o     (a_oe_o),
  .b_o        (b_o),
  .b_oe_o     (b_oe_o)
);

// File: tb/exch_narrow_wide_test.sv
`timescale 1ns/1ps
module exch_narrow_wide_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] a_i = '0;
  logic [23:0] b_i = '0;
  logic clken_lo_ni = 1'b1, clken_hi_ni = 1'b1, clken_blo_ni = 1'b1, clken_bhi_ni = 1'b1;
  logic sel_ni = 1'b1, oea_ni = 1'b1, oeb_ni = 1'b1;
  logic [11:0] a_o;
  logic        a_oe_o;
  logic [23:0] b_o;
  logic        b_oe_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  int          due_q[$];
  bit          port_q[$];
  logic [24:0] val_q[$];
  string       req_q[$];

  always #4 clk_i = ~clk_i;

  exch_narrow_wide uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .clken_lo_ni(clken_lo_ni), .clken_hi_ni(clken_hi_ni),
    .clken_blo_ni(clken_blo_ni), .clken_bhi_ni(clken_bhi_ni),
    .sel_ni(sel_ni), .oea_ni(oea_ni), .oeb_ni(oeb_ni),
    .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  task automatic check(string req, logic [24:0] act, logic [24:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side: expectation for the result after the coming edge
  task automatic expect_b(logic oe, logic [23:0] d, string req);
    due_q.push_back(cyc + 1); port_q.push_back(1'b1);
    val_q.push_back({oe, d}); req_q.push_back(req);
  endtask

  task automatic expect_a(logic oe, logic [11:0] d, string req);
    due_q.push_back(cyc + 1); port_q.push_back(1'b0);
    val_q.push_back({oe, 12'h000, d}); req_q.push_back(req);
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    clken_lo_ni = 1'b1; clken_hi_ni = 1'b1;
    clken_blo_ni = 1'b1; clken_bhi_ni = 1'b1;
  endtask

  // monitor: pops due items shortly after each edge
  always @(posedge clk_i) begin
    cyc++;
    #2;
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      logic [24:0] act;
      act = port_q[0] ? {b_oe_o, b_o} : {a_oe_o, 12'h000, a_o};
      check(req_q[0], act, val_q[0]);
      void'(due_q.pop_front()); void'(port_q.pop_front());
      void'(val_q.pop_front()); void'(req_q.pop_front());
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 idle", {a_oe_o, b_oe_o, a_o, b_o} == '0 ? 25'd0 : 25'd1, 25'd0);
    repeat (3) tick();
    check("R1 held", {1'b0, a_oe_o, b_oe_o, 10'h0, a_o}, 25'd0);
    rst_ni = 1'b1;
    tick();

    // R2: enable B; registered so no change before the edge
    oeb_ni = 1'b0;
    #1 check("R2 pre-edge", {24'h0, b_oe_o}, 25'd0);
    expect_b(1'b1, 24'h000000, "R2");
    tick();

    // R6: pair two narrow words
    a_i = 12'h3A5; clken_lo_ni = 1'b0;
    expect_b(1'b1, 24'h000000, "R5 first stage only");
    tick();
    a_i = 12'hC5A; clken_hi_ni = 1'b0;
    expect_b(1'b1, {12'hC5A, 12'h3A5}, "R6");
    tick();

    // R4/R5 hold with enables high
    idle(); a_i = 12'hFFF;
    expect_b(1'b1, {12'hC5A, 12'h3A5}, "R4 hold");
    tick();

    // R5 walk the lo pipeline
    a_i = 12'h111; clken_lo_ni = 1'b0;
    expect_b(1'b1, {12'hC5A, 12'hC5A}, "R5");
    tick();
    a_i = 12'h222;
    expect_b(1'b1, {12'hC5A, 12'h111}, "R5");
    tick();
    a_i = 12'h333;
    expect_b(1'b1, {12'hC5A, 12'h222}, "R5");
    tick();

    // R4 hi capture alone, lo held
    a_i = 12'h0F0; clken_lo_ni = 1'b1; clken_hi_ni = 1'b0;
    expect_b(1'b1, {12'h0F0, 12'h222}, "R4 capture");
    tick();

    // R3 B disabled
    idle(); a_i = 12'h555; oeb_ni = 1'b1;
    expect_b(1'b0, 24'h000000, "R3 B quiet");
    tick();

    // R7/R8 wide to narrow
    b_i = {12'h123, 12'hABC}; clken_blo_ni = 1'b0; clken_bhi_ni = 1'b0;
    oea_ni = 1'b0; sel_ni = 1'b0;
    #1 check("R2 A pre-edge", {24'h0, a_oe_o}, 25'd0);
    expect_a(1'b1, 12'hABC, "R7");
    expect_b(1'b0, 24'h000000, "R3 B still quiet");
    tick();
    idle(); b_i = {12'h789, 12'h456}; sel_ni = 1'b1;
    #1 check("R8 pre-edge", {13'h0, a_o}, {13'h0, 12'hABC});
    expect_a(1'b1, 12'h123, "R8");
    tick();
    clken_blo_ni = 1'b0; sel_ni = 1'b0;
    expect_a(1'b1, 12'h456, "R7");
    tick();
    idle(); sel_ni = 1'b1;
    expect_a(1'b1, 12'h123, "R7 hi held");
    tick();

    // R3 A disabled; R4 B re-enabled shows held state
    oea_ni = 1'b1; oeb_ni = 1'b0;
    expect_a(1'b0, 12'h000, "R3 A quiet");
    expect_b(1'b1, {12'h0F0, 12'h222}, "R4 held while quiet");
    tick();

    repeat (3) tick();
    check("queue drained", {7'h0, 18'(due_q.size())}, 25'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule